// File: doc/BRIEF.md
# Descriptor-Ring DMA Channel

This block is one DMA channel that works through a ring of buffer descriptors kept in a small local descriptor store. Each descriptor gives a source address, a destination address, a byte count and a handful of flag bits. Software fills the descriptors, picks a mode and sets the start bit. The channel then loads the current descriptor into working registers. It moves one data word per beat over a simple request/grant memory port: a read from the source, then a write to the destination. When the count runs out it writes the descriptor back and goes on to the next one.

Two modes decide when the run ends. In auto-buffer mode the channel goes on until it finds a descriptor that software has not handed over, and reports that as an out-of-buffers error. In buffer-chaining mode a descriptor marked as last ends the run with a done status. An external done input can cut the current descriptor short in either mode, and each mode records that in its own way. A mode register carries start, reset and mode bits. Status and mask bits drive one interrupt line. An init command, given while the reset bit is set, puts the channel back at descriptor zero.

Top module: `dma_bd_chan`

## Requirements
- R1: After reset, chan_state is IDLE (encoding 0), mode_start, mode_rst, stat_done, stat_oob and irq are low, and mem_req is low.
- R2: A beat first reads the word at the working source address and then writes that same word to the working destination address. Both addresses then advance by 4 and the remaining count drops by 4. A write request keeps mem_req, mem_wr and mem_addr steady until mem_gnt is seen.
- R3: When the count of a descriptor reaches zero, the descriptor is written back with its own bit (bit 48) cleared and its count (bits 11:0) at zero. The channel then fetches the next index in either mode, or index 0 when the finished descriptor had its wrap bit (bit 47) set or was the last entry of the store.
- R4: When the fetched descriptor has its own bit clear, the channel goes to STOPPED (encoding 5), sets stat_oob, clears mode_start and leaves stat_done unchanged. In auto-buffer mode (mode_chain_w = 0) the last bit (bit 46) has no effect.
- R5: In buffer-chaining mode (mode_chain_w = 1), finishing a descriptor whose last bit is set writes it back, sets stat_done, clears mode_start and enters STOPPED.
- R6: irq is high exactly when stat_done is set with mask bit 0 set, or stat_oob is set with mask bit 1 set.
- R7: stat_done and stat_oob stay set until software writes a one to bit 0 or bit 1 of the write-one-to-clear port.
- R8: In auto-buffer mode, ext_done seen during XFER (encoding 2) ends the descriptor at once. The write-back stores the remaining count, sets the done-seen flag (bit 45) and clears the own bit. The channel then sets stat_done, clears mode_start, leaves mode_rst low and enters STOPPED.
- R9: In buffer-chaining mode, ext_done seen during XFER writes back the remaining count, sets the abort flag (bit 44) and clears the own bit. The channel then sets stat_done, clears mode_start, sets mode_rst and enters STOPPED.
- R10: Clearing mode_start during a transfer stops requests at the next beat boundary and enters SUSPENDED (encoding 4). Setting it again continues with the next word, with no word skipped or repeated.
- R11: init_cmd while mode_rst is set returns the channel to IDLE at descriptor index 0 and clears mode_start and mode_rst. init_cmd while mode_rst is clear has no effect.
- R12: STOPPED is left only through R11; setting mode_start while stopped issues no request.
- R13: ext_done outside XFER has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_start_w | input | 1 | Start bit value to write |
| mode_rst_w | input | 1 | Reset bit value to write |
| mode_chain_w | input | 1 | Mode to write: 0 auto-buffer, 1 buffer-chaining |
| init_cmd | input | 1 | Init command pulse |
| imask_we | input | 1 | Write strobe for the interrupt mask |
| imask_w | input | 2 | Mask: bit 0 done, bit 1 out-of-buffers |
| stat_w1c_we | input | 1 | Write strobe for status clear |
| stat_w1c | input | 2 | Ones clear status: bit 0 done, bit 1 out-of-buffers |
| bd_sw_we | input | 1 | Software descriptor write strobe |
| bd_sw_addr | input | 3 | Software descriptor write index |
| bd_sw_wdata | input | 49 | Descriptor to write |
| bd_sw_raddr | input | 3 | Software descriptor read index |
| bd_sw_rdata | output | 49 | Descriptor at bd_sw_raddr |
| ext_done | input | 1 | External done request |
| mem_req | output | 1 | Memory request |
| mem_wr | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| mode_start | output | 1 | Start bit |
| mode_rst | output | 1 | Reset bit |
| stat_done | output | 1 | Done status |
| stat_oob | output | 1 | Out-of-buffers status |
| irq | output | 1 | Interrupt |
| chan_state | output | 3 | Channel state |

## Verification
The bench targets the ends of a descriptor run. It checks that an auto-buffer run ignores a last flag and stops only at a descriptor not handed over. Without that, the run would either stop early or move data from a stale buffer. A wrap flag must send the fetch back to entry zero, not on to a handed-over later entry. The external done cases check the remaining count and the mode-specific flag in the write-back. A design that swapped the done-seen and abort flags, or forgot to set the reset bit in buffer-chaining mode, would fail there. A suspend in the middle of a run must resume without losing or repeating a word, which the scoreboard would catch as an address mismatch.

// File: rtl/dma_pkg.sv
package dma_pkg;
    parameter int ADDR_W = 16;
    parameter int CNT_W  = 12;
    parameter int DATA_W = 32;
    localparam int BPW   = DATA_W / 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] word_t;

    // Descriptor layout, most significant field first
    typedef struct packed {
        logic  own;    // handed to the channel (valid / ready)
        logic  wrap;   // next fetch goes to entry zero
        logic  last;   // ends a buffer-chaining run
        logic  dseen;  // external done hit this buffer (auto-buffer)
        logic  abrt;   // external done hit this buffer (buffer-chaining)
        addr_t src;
        addr_t dst;
        cnt_t  cnt;
    } bd_t;

    localparam int BD_W = $bits(bd_t);

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FETCH_BD  = 3'd1,
        ST_XFER      = 3'd2,
        ST_WRITEBACK = 3'd3,
        ST_SUSPENDED = 3'd4,
        ST_STOPPED   = 3'd5
    } chan_st_e;

    typedef enum logic {PH_RD = 1'b0, PH_WR = 1'b1} beat_ph_e;

    // Descriptor image stored when a buffer is closed
    function automatic bd_t bd_close(bd_t b, cnt_t left, logic by_ext, logic chain);
        bd_t r;
        r       = b;
        r.own   = 1'b0;
        r.cnt   = left;
        r.dseen = b.dseen | (by_ext & ~chain);
        r.abrt  = b.abrt  | (by_ext &  chain);
        return r;
    endfunction
endpackage

// File: rtl/dma_bd_mem.sv
module dma_bd_mem
    import dma_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_waddr,
    input  bd_t              sw_wdata,
    input  logic [IDX_W-1:0] sw_raddr,
    output bd_t              sw_rdata,
    input  logic [IDX_W-1:0] ch_raddr,
    output bd_t              ch_rdata,
    input  logic             ch_we,
    input  logic [IDX_W-1:0] ch_waddr,
    input  bd_t              ch_wdata
);
    bd_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else begin
            if (sw_we) store[sw_waddr] <= sw_wdata;
            // channel write-back wins on a shared index
            if (ch_we) store[ch_waddr] <= ch_wdata;
        end
    end

    assign sw_rdata = store[sw_raddr];
    assign ch_rdata = store[ch_raddr];
endmodule

// File: rtl/dma_status.sv
module dma_status #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_evt,
    input  logic            w1c_we,
    input  logic [NSRC-1:0] w1c,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_w,
    output logic [NSRC-1:0] flags,
    output logic            irq
);
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_w;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst)                    f_q <= 1'b0;
            else if (set_evt[g])        f_q <= 1'b1;
            else if (w1c_we && w1c[g])  f_q <= 1'b0;
        end
        assign flags[g] = f_q;
        assign hit[g]   = f_q & mask_q[g];
    end

    assign irq = |hit;
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_we,
    input  logic             mode_start_w,
    input  logic             mode_rst_w,
    input  logic             mode_chain_w,
    input  logic             init_cmd,
    input  logic             ext_done,
    // descriptor store
    output logic [IDX_W-1:0] bd_idx,
    input  bd_t              bd_rd,
    output logic             bd_we,
    output bd_t              bd_wd,
    // memory port
    output logic             mem_req,
    output logic             mem_wr,
    output addr_t            mem_addr,
    output word_t            mem_wdata,
    input  logic             mem_gnt,
    input  word_t            mem_rdata,
    // events and visible state
    output logic             ev_done,
    output logic             ev_oob,
    output logic             start_o,
    output logic             rst_o,
    output chan_st_e         state_o
);
    localparam cnt_t  CNT_STEP  = cnt_t'(BPW);
    localparam addr_t ADDR_STEP = addr_t'(BPW);

    chan_st_e         st_q;
    beat_ph_e         ph_q;
    logic             start_q, rst_q, chain_q, ext_q;
    logic [IDX_W-1:0] idx_q, idx_nxt;
    bd_t              cur_q;
    addr_t            src_q, dst_q;
    cnt_t             cnt_q;
    word_t            buf_q;
    logic             do_init, beat_done, last_beat, chain_end;

    assign do_init   = init_cmd && rst_q;
    assign beat_done = (st_q == ST_XFER) && (ph_q == PH_WR) && mem_gnt;
    assign last_beat = beat_done && (cnt_q == CNT_STEP);
    assign chain_end = chain_q && cur_q.last;

    always_comb begin
        if (cur_q.wrap || idx_q == IDX_W'(DEPTH-1)) idx_nxt = '0;
        else                                        idx_nxt = idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ph_q    <= PH_RD;
            start_q <= 1'b0;
            rst_q   <= 1'b0;
            chain_q <= 1'b0;
            ext_q   <= 1'b0;
            idx_q   <= '0;
            cur_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            buf_q   <= '0;
        end else begin
            if (do_init) begin
                st_q    <= ST_IDLE;
                ph_q    <= PH_RD;
                idx_q   <= '0;
                start_q <= 1'b0;
                rst_q   <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (start_q) st_q <= ST_FETCH_BD;
                    end
                    ST_FETCH_BD: begin
                        cur_q <= bd_rd;
                        src_q <= bd_rd.src;
                        dst_q <= bd_rd.dst;
                        cnt_q <= bd_rd.cnt;
                        ph_q  <= PH_RD;
                        ext_q <= 1'b0;
                        if (!bd_rd.own) begin
                            st_q    <= ST_STOPPED;
                            start_q <= 1'b0;
                        end else if (bd_rd.cnt == '0) begin
                            st_q <= ST_WRITEBACK;
                        end else begin
                            st_q <= ST_XFER;
                        end
                    end
                    ST_XFER: begin
                        if (mem_gnt && mem_req) begin
                            if (ph_q == PH_RD) begin
                                buf_q <= mem_rdata;
                                ph_q  <= PH_WR;
                            end else begin
                                src_q <= src_q + ADDR_STEP;
                                dst_q <= dst_q + ADDR_STEP;
                                cnt_q <= cnt_q - CNT_STEP;
                                ph_q  <= PH_RD;
                            end
                        end
                        if (ext_done) begin
                            ext_q <= 1'b1;
                            st_q  <= ST_WRITEBACK;
                        end else if (last_beat) begin
                            st_q <= ST_WRITEBACK;
                        end else if (ph_q == PH_RD && !start_q) begin
                            st_q <= ST_SUSPENDED;
                        end
                    end
                    ST_WRITEBACK: begin
                        if (ext_q) begin
                            st_q    <= ST_STOPPED;
                            start_q <= 1'b0;
                            if (chain_q) rst_q <= 1'b1;
                        end else if (chain_end) begin
                            st_q    <= ST_STOPPED;
                            start_q <= 1'b0;
                        end else begin
                            idx_q <= idx_nxt;
                            st_q  <= ST_FETCH_BD;
                        end
                    end
                    ST_SUSPENDED: begin
                        if (start_q) st_q <= ST_XFER;
                    end
                    ST_STOPPED: begin
                        st_q <= ST_STOPPED;
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
            // a software write to the mode register wins over the channel
            if (mode_we) begin
                start_q <= mode_start_w;
                rst_q   <= mode_rst_w;
                chain_q <= mode_chain_w;
            end
        end
    end

    // memory port
    assign mem_req   = (st_q == ST_XFER) && ((ph_q == PH_WR) || start_q);
    assign mem_wr    = (ph_q == PH_WR);
    assign mem_addr  = (ph_q == PH_WR) ? dst_q : src_q;
    assign mem_wdata = buf_q;

    // descriptor write-back
    assign bd_idx = idx_q;
    assign bd_we  = (st_q == ST_WRITEBACK) && !do_init;
    assign bd_wd  = bd_close(cur_q, cnt_q, ext_q, chain_q);

    // status events
    assign ev_done = bd_we && (ext_q || chain_end);
    assign ev_oob  = (st_q == ST_FETCH_BD) && !bd_rd.own && !do_init;

    assign start_o = start_q;
    assign rst_o   = rst_q;
    assign state_o = st_q;
endmodule

// File: rtl/dma_bd_chan.sv
module dma_bd_chan
    import dma_pkg::*;
#(
    parameter int BD_DEPTH = 8,
    localparam int IDX_W = $clog2(BD_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic              mode_start_w,
    input  logic              mode_rst_w,
    input  logic              mode_chain_w,
    input  logic              init_cmd,
    input  logic              imask_we,
    input  logic [1:0]        imask_w,
    input  logic              stat_w1c_we,
    input  logic [1:0]        stat_w1c,
    input  logic              bd_sw_we,
    input  logic [IDX_W-1:0]  bd_sw_addr,
    input  logic [BD_W-1:0]   bd_sw_wdata,
    input  logic [IDX_W-1:0]  bd_sw_raddr,
    output logic [BD_W-1:0]   bd_sw_rdata,
    input  logic              ext_done,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mode_start,
    output logic              mode_rst,
    output logic              stat_done,
    output logic              stat_oob,
    output logic              irq,
    output logic [2:0]        chan_state
);
    logic [IDX_W-1:0] ch_idx;
    bd_t              ch_rd, ch_wd, sw_rd;
    logic             ch_we, ev_done, ev_oob;
    logic [1:0]       flags;
    chan_st_e         st;

    dma_bd_mem #(.DEPTH(BD_DEPTH)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (bd_sw_we),
        .sw_waddr (bd_sw_addr),
        .sw_wdata (bd_t'(bd_sw_wdata)),
        .sw_raddr (bd_sw_raddr),
        .sw_rdata (sw_rd),
        .ch_raddr (ch_idx),
        .ch_rdata (ch_rd),
        .ch_we    (ch_we),
        .ch_waddr (ch_idx),
        .ch_wdata (ch_wd)
    );

    dma_chan_fsm #(.DEPTH(BD_DEPTH)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .mode_we      (mode_we),
        .mode_start_w (mode_start_w),
        .mode_rst_w   (mode_rst_w),
        .mode_chain_w (mode_chain_w),
        .init_cmd     (init_cmd),
        .ext_done     (ext_done),
        .bd_idx       (ch_idx),
        .bd_rd        (ch_rd),
        .bd_we        (ch_we),
        .bd_wd        (ch_wd),
        .mem_req      (mem_req),
        .mem_wr       (mem_wr),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_gnt      (mem_gnt),
        .mem_rdata    (mem_rdata),
        .ev_done      (ev_done),
        .ev_oob       (ev_oob),
        .start_o      (mode_start),
        .rst_o        (mode_rst),
        .state_o      (st)
    );

    dma_status #(.NSRC(2)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_evt ({ev_oob, ev_done}),
        .w1c_we  (stat_w1c_we),
        .w1c     (stat_w1c),
        .mask_we (imask_we),
        .mask_w  (imask_w),
        .flags   (flags),
        .irq     (irq)
    );

    assign bd_sw_rdata = sw_rd;
    assign stat_done   = flags[0];
    assign stat_oob    = flags[1];
    assign chan_state  = st;
endmodule

// File: rtl/dma_bd_chan_chk.sv
module dma_bd_chan_chk (
    input logic       clk,
    input logic       rst,
    input logic       init_cmd,
    input logic       stat_w1c_we,
    input logic [1:0] stat_w1c,
    input logic       ext_done,
    input logic       mem_req,
    input logic       mem_wr,
    input logic [15:0] mem_addr,
    input logic       mem_gnt,
    input logic       mode_rst,
    input logic       stat_done,
    input logic       stat_oob,
    input logic       irq,
    input logic [2:0] chan_state
);
    // R2: an ungranted write stays put
    a_r2_wr_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_wr && !mem_gnt && !ext_done && !(init_cmd && mode_rst))
        |=> (mem_req && mem_wr && $stable(mem_addr)));

    // R10: no request outside an active transfer
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        (chan_state == 3'd4 || chan_state == 3'd0 || chan_state == 3'd5) |-> !mem_req);

    // R8: external done during XFER goes straight to write-back
    a_r8_ext_wb: assert property (@(posedge clk) disable iff (rst)
        (chan_state == 3'd2 && ext_done && !(init_cmd && mode_rst)) |=> (chan_state == 3'd3));

    // R12: stopped is held until a reset-init
    a_r12_stop_hold: assert property (@(posedge clk) disable iff (rst)
        (chan_state == 3'd5 && !(init_cmd && mode_rst)) |=> (chan_state == 3'd5));

    // R7: out-of-buffers flag is sticky
    a_r7_oob_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_oob && !(stat_w1c_we && stat_w1c[1])) |=> stat_oob);

    // R6: no interrupt without a status flag
    a_r6_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (!stat_done && !stat_oob) |-> !irq);
endmodule

bind dma_bd_chan dma_bd_chan_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .init_cmd    (init_cmd),
    .stat_w1c_we (stat_w1c_we),
    .stat_w1c    (stat_w1c),
    .ext_done    (ext_done),
    .mem_req     (mem_req),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .mem_gnt     (mem_gnt),
    .mode_rst    (mode_rst),
    .stat_done   (stat_done),
    .stat_oob    (stat_oob),
    .irq         (irq),
    .chan_state  (chan_state)
);

// File: tb/tb_dma_bd_chan.sv
module tb_dma_bd_chan;
    import dma_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_we = 0, mode_start_w = 0, mode_rst_w = 0, mode_chain_w = 0;
    logic init_cmd = 0, imask_we = 0, stat_w1c_we = 0;
    logic [1:0] imask_w = 0, stat_w1c = 0;
    logic bd_sw_we = 0;
    logic [2:0] bd_sw_addr = 0, bd_sw_raddr = 0;
    logic [BD_W-1:0] bd_sw_wdata = '0, bd_sw_rdata;
    logic ext_done = 0;
    logic mem_req, mem_wr, mem_gnt;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic mode_start, mode_rst, stat_done, stat_oob, irq;
    logic [2:0] chan_state;

    logic hold = 0, slow = 0, cyc = 0;
    int total = 0, bad = 0, beats = 0;
    logic [47:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= ~cyc;

    function automatic logic [31:0] pat(logic [15:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    assign mem_rdata = pat(mem_addr);
    assign mem_gnt   = mem_req && !hold && (!slow || cyc);

    dma_bd_chan dut (.*);

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // monitor: compare every granted write against the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_req && mem_gnt && mem_wr) begin
            beats++;
            total++;
            if (expq.size() == 0) begin
                bad++;
                $display("FAIL R2 actual=%0h expected=none", {mem_addr, mem_wdata});
            end else begin
                logic [47:0] e;
                e = expq.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    bad++;
                    $display("FAIL R2 actual=%0h expected=%0h", {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    task automatic push_beats(input logic [15:0] s, input logic [15:0] d, input int n);
        for (int k = 0; k < n; k += 4) expq.push_back({d + 16'(k), pat(s + 16'(k))});
    endtask

    function automatic bd_t mk(logic own, logic wrap, logic last,
                               logic [15:0] s, logic [15:0] d, logic [11:0] n);
        bd_t b;
        b = '0;
        b.own = own; b.wrap = wrap; b.last = last;
        b.src = s; b.dst = d; b.cnt = n;
        return b;
    endfunction

    task automatic bd_write(input int i, input bd_t b);
        @(negedge clk);
        bd_sw_we = 1; bd_sw_addr = 3'(i); bd_sw_wdata = b;
        @(negedge clk);
        bd_sw_we = 0;
    endtask

    task automatic bd_read(input int i, output bd_t b);
        @(negedge clk);
        bd_sw_raddr = 3'(i);
        #1 b = bd_t'(bd_sw_rdata);
    endtask

    task automatic mode(input logic s, input logic r, input logic c);
        @(negedge clk);
        mode_we = 1; mode_start_w = s; mode_rst_w = r; mode_chain_w = c;
        @(negedge clk);
        mode_we = 0;
    endtask

    task automatic pulse_init();
        @(negedge clk); init_cmd = 1;
        @(negedge clk); init_cmd = 0;
    endtask

    task automatic set_mask(input logic [1:0] m);
        @(negedge clk); imask_we = 1; imask_w = m;
        @(negedge clk); imask_we = 0;
    endtask

    task automatic w1c(input logic [1:0] v);
        @(negedge clk); stat_w1c_we = 1; stat_w1c = v;
        @(negedge clk); stat_w1c_we = 0;
    endtask

    task automatic wait_state(input logic [2:0] st, input string rq);
        int n;
        n = 0;
        while (chan_state !== st && n < 2000) begin @(negedge clk); n++; end
        check(rq, chan_state, st);
    endtask

    task automatic reinit();
        mode(0, 1, 0);
        pulse_init();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bd_t b;
        int  nb;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        check("R1 state", chan_state, 0);
        check("R1 flags", {mode_start, mode_rst, stat_done, stat_oob, irq, mem_req}, 0);

        // R13 ext_done while idle
        @(negedge clk) ext_done = 1;
        @(negedge clk) ext_done = 0;
        repeat (2) @(negedge clk);
        check("R13 idle state", chan_state, 0);
        check("R13 done", stat_done, 0);

        // auto-buffer run: last ignored, reload, out-of-buffers stop
        set_mask(2'b10);
        bd_write(0, mk(1, 0, 1, 16'h0100, 16'h0800, 12'd8));
        bd_write(1, mk(1, 0, 0, 16'h0200, 16'h0900, 12'd4));
        bd_write(2, mk(0, 0, 0, 16'h0300, 16'h0A00, 12'd4));
        push_beats(16'h0100, 16'h0800, 8);
        push_beats(16'h0200, 16'h0900, 4);
        mode(1, 0, 0);
        wait_state(3'd5, "R4 stop");
        check("R3 all beats", expq.size(), 0);
        check("R4 oob", stat_oob, 1);
        check("R4 done", stat_done, 0);
        check("R4 start", mode_start, 0);
        check("R6 irq oob", irq, 1);
        bd_read(0, b);
        check("R3 wb0", {b.own, b.cnt}, 0);
        bd_read(1, b);
        check("R3 wb1", {b.own, b.cnt}, 0);
        // R12 start while stopped
        nb = beats;
        mode(1, 0, 0);
        repeat (6) @(negedge clk);
        check("R12 stays", chan_state, 5);
        check("R12 no beats", beats, nb);
        // R11 init without reset bit
        mode(0, 0, 0);
        pulse_init();
        @(negedge clk);
        check("R11 ignored", chan_state, 5);
        // R7 w1c
        w1c(2'b01);
        check("R7 other bit kept", stat_oob, 1);
        w1c(2'b10);
        check("R7 oob cleared", stat_oob, 0);
        check("R6 irq low", irq, 0);
        reinit();
        check("R11 idle", chan_state, 0);
        check("R11 bits", {mode_start, mode_rst}, 0);

        // wrap: index 0 after wrap bit, entry 1 untouched (also shows R11 index reset)
        bd_write(0, mk(1, 1, 0, 16'h0300, 16'h0A00, 12'd4));
        bd_write(1, mk(1, 0, 0, 16'h0400, 16'h0B00, 12'd4));
        push_beats(16'h0300, 16'h0A00, 4);
        mode(1, 0, 0);
        wait_state(3'd5, "R3 wrap stop");
        check("R3 wrap beats", expq.size(), 0);
        bd_read(1, b);
        check("R3 wrap skip", b.own, 1);
        w1c(2'b11);
        reinit();

        // buffer-chaining with last, stalled grants
        set_mask(2'b01);
        slow = 1;
        bd_write(0, mk(1, 0, 0, 16'h0500, 16'h0C00, 12'd4));
        bd_write(1, mk(1, 0, 1, 16'h0600, 16'h0D00, 12'd8));
        bd_write(2, mk(1, 0, 0, 16'h0700, 16'h0E00, 12'd4));
        push_beats(16'h0500, 16'h0C00, 4);
        push_beats(16'h0600, 16'h0D00, 8);
        mode(1, 0, 1);
        wait_state(3'd5, "R5 stop");
        check("R5 beats", expq.size(), 0);
        check("R5 done", stat_done, 1);
        check("R5 oob", stat_oob, 0);
        check("R6 irq done", irq, 1);
        check("R5 mode bits", {mode_start, mode_rst}, 0);
        bd_read(1, b);
        check("R5 wb last", {b.own, b.cnt}, 0);
        bd_read(2, b);
        check("R5 next untouched", b.own, 1);
        w1c(2'b01);
        check("R7 done cleared", stat_done, 0);
        slow = 0;
        reinit();

        // suspend and resume
        bd_write(0, mk(1, 0, 0, 16'h0100, 16'h0F00, 12'd32));
        bd_write(1, mk(0, 0, 0, 16'h0000, 16'h0000, 12'd0));
        push_beats(16'h0100, 16'h0F00, 32);
        nb = beats;
        mode(1, 0, 0);
        wait (beats == nb + 1);
        mode(0, 0, 0);
        repeat (4) @(negedge clk);
        check("R10 suspended", chan_state, 4);
        nb = beats;
        repeat (8) @(negedge clk);
        check("R10 no beats", beats, nb);
        check("R10 no req", mem_req, 0);
        mode(1, 0, 0);
        wait_state(3'd5, "R10 resume stop");
        check("R10 all beats", expq.size(), 0);
        w1c(2'b11);
        reinit();

        // external done, auto-buffer
        set_mask(2'b00);
        bd_write(0, mk(1, 0, 0, 16'h0100, 16'h1000, 12'd40));
        push_beats(16'h0100, 16'h1000, 40);
        nb = beats;
        mode(1, 0, 0);
        wait (beats == nb + 2);
        @(posedge clk); #1 hold = 1;
        @(negedge clk) ext_done = 1;
        @(negedge clk) ext_done = 0;
        wait_state(3'd5, "R8 stop");
        check("R8 done", stat_done, 1);
        check("R6 masked", irq, 0);
        check("R8 mode bits", {mode_start, mode_rst}, 0);
        bd_read(0, b);
        check("R8 wb", {b.own, b.dseen, b.abrt, b.cnt}, {1'b0, 1'b1, 1'b0, 12'd32});
        check("R8 left", expq.size(), 8);
        expq.delete();
        hold = 0;
        w1c(2'b11);
        reinit();

        // external done, buffer-chaining
        bd_write(0, mk(1, 0, 0, 16'h0100, 16'h1100, 12'd40));
        push_beats(16'h0100, 16'h1100, 40);
        nb = beats;
        mode(1, 0, 1);
        wait (beats == nb + 2);
        @(posedge clk); #1 hold = 1;
        @(negedge clk) ext_done = 1;
        @(negedge clk) ext_done = 0;
        wait_state(3'd5, "R9 stop");
        check("R9 done", stat_done, 1);
        check("R9 mode bits", {mode_start, mode_rst}, 2'b01);
        bd_read(0, b);
        check("R9 wb", {b.own, b.dseen, b.abrt, b.cnt}, {1'b0, 1'b0, 1'b1, 12'd32});
        expq.delete();
        hold = 0;
        pulse_init();
        @(negedge clk);
        check("R11 init after abort", {chan_state, mode_rst}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule